// File: doc/BRIEF.md
# Attributed Bitmap Pixel Serializer

This block sits between a display timing generator and the memory arbiter of a video subsystem. During each 640-cycle pixel window of a scanline it requests 1-bit-per-pixel bitmap bytes from memory and turns every byte into eight pixels. Each pixel can be repeated for one to four cycles, which gives 80, 40, 26 or 20 character columns per line. Each pixel leaves the block as a 4-bit colour index.

When pixels are repeated, memory bandwidth is left over. The block can use that spare bandwidth to read colour attribute bytes between the bitmap reads. An attribute read during one column is applied to the next column, so the first column of the line is used only for the opening attribute read and is output blank. Attributes are read only on the first pixel row of a character row. They are kept in a one-row buffer and used again for the next seven rows. There are two attribute modes. In the full mode, one byte per character holds a foreground and a background colour. In the half mode, one byte covers two neighbouring characters and holds one foreground colour for each, with a fixed black background.

The timing generator provides a line-start pulse, the pixel-window flag, the pixel row within the character, and the start addresses of the bitmap and the attributes for the line. Memory returns read data in the same cycle as the request.

Top module: `attrser_top`

## Requirements
- R1: Bitmap bits are output most significant bit first. Each bit is held for S cycles, where S is 1, 2, 3 or 4 and is selected by `scale_sel` values 0, 1, 2 and 3. The colour for window position c (counted from 0 on the first cycle with `win` high) appears on `pix_out` two cycles later.
- R2: A character column lasts 8·S window cycles. There are 80, 40, 26 or 20 columns. Window positions past the last column are output as colour 0, which covers the final 16 cycles at S = 3.
- R3: With attributes off (`attr_sel` 0), character j is shown in column j. A bit of 1 gives colour 7 and a bit of 0 gives colour 0. Character j is read at `line_addr` + 8·j in the first cycle of its column. Exactly one read is made per column.
- R4: With attributes on, column 0 is blank and character j is shown in column j+1. Its bitmap byte is read at `line_addr` + 8·j in the first cycle of that column. Its attribute is read 4·S cycles into column j. No two reads are made in consecutive cycles.
- R5: Full attribute mode (`attr_sel` 1) reads the attribute of character j at `attr_addr` + j. A bit of 1 takes the high nibble of the attribute and a bit of 0 takes the low nibble.
- R6: Half attribute mode (`attr_sel` 2) reads only in columns with an even j, at `attr_addr` + j/2. A bit of 1 takes the high nibble for an even character and the low nibble for an odd character. A bit of 0 gives colour 0.
- R7: Attributes are read only when `row_in_char` is 0. On rows 1 to 7 no attribute read is made, and each character uses the attribute buffered on row 0, even if memory or `attr_addr` has changed since.
- R8: At S = 1, and for `attr_sel` 3, the block works as if `attr_sel` were 0.
- R9: `pix_out` is 0 when its window position is outside the window, and during and straight after reset. `fetch_req` is asserted only while `win` is high.
- R10: Scale, attribute mode, row, and both addresses are captured on `line_start`. Changes to these inputs during the line have no effect until the next `line_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-cycle pulse before the window of each line |
| win | input | 1 | High for the 640 cycles of the pixel window |
| row_in_char | input | 3 | Pixel row within the current character row |
| scale_sel | input | 2 | Pixel repeat count minus one |
| attr_sel | input | 2 | 0 off, 1 full, 2 half, 3 off |
| line_addr | input | 16 | Address of character 0's byte on this line |
| attr_addr | input | 16 | Address of the first attribute byte of the character row |
| fetch_req | output | 1 | Memory read request |
| fetch_addr | output | 16 | Read address |
| fetch_data | input | 8 | Read data, valid in the cycle of the request |
| pix_out | output | 4 | Colour index |

## Verification
A fault in the position counters shows up within two cycles as pixels shifted, stretched or taken from the wrong bit, and as read addresses that fall in the wrong cycle. A fault in attribute buffer writes or pointers can hide on the first row, because the same data is used there as soon as it is read. It appears only one to seven lines later, when rows 1 to 7 read back the stored bytes after memory has changed. The bench therefore changes the memory contents and `attr_addr` on every row. It also counts the reads made on each line, which shows extra or missing attribute reads.

// File: rtl/attrser_pkg.sv
package attrser_pkg;

    localparam int PIX_PER_LINE = 640;
    localparam int BYTE_PIX     = 8;
    localparam int COL_W        = 7;

    typedef enum logic [1:0] {SC_X1, SC_X2, SC_X3, SC_X4} scale_e;
    typedef enum logic [1:0] {AT_NONE, AT_FULL, AT_HALF, AT_RSVD} attr_e;

    typedef struct packed {
        scale_e     scale;
        attr_e      attr;
        logic [2:0] row;
    } line_cfg_t;

    typedef struct packed {
        logic             valid;
        logic [COL_W-1:0] col;
        logic [2:0]       bitn;
    } pos_t;

    // number of whole character columns in the window
    function automatic logic [COL_W-1:0] cols_of(scale_e s);
        return COL_W'(PIX_PER_LINE / (BYTE_PIX * (int'(s) + 1)));
    endfunction

    // attributes need spare bandwidth: none at x1, code 3 means off
    function automatic attr_e eff_attr(scale_e s, attr_e a);
        if (s == SC_X1 || a == AT_RSVD) return AT_NONE;
        return a;
    endfunction

endpackage

// File: rtl/attrser_timing.sv
module attrser_timing
    import attrser_pkg::*;
#(
    parameter int AW = 16,
    parameter int IW = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            line_start,
    input  logic            win,
    input  logic [2:0]      row_i,
    input  scale_e          scale_i,
    input  attr_e           attr_i,
    input  logic [AW-1:0]   laddr_i,
    input  logic [AW-1:0]   aaddr_i,
    output line_cfg_t       cfg_o,
    output pos_t            pos_o,
    output logic            bmp_fetch_o,
    output logic            attr_fetch_o,
    output logic [IW-1:0]   wr_ptr_o,
    output logic [AW-1:0]   addr_o
);

    line_cfg_t        cfg_q;
    logic [AW-1:0]    laddr_q, aaddr_q;
    logic [1:0]       rep_q;
    logic [2:0]       bit_q;
    logic [COL_W-1:0] col_q;
    logic [IW-1:0]    wr_ptr_q;

    logic [COL_W-1:0] ncols, bmp_char;
    logic             slot_start;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.scale <= SC_X1;
            cfg_q.attr  <= AT_NONE;
            cfg_q.row   <= '0;
            laddr_q     <= '0;
            aaddr_q     <= '0;
            rep_q       <= '0;
            bit_q       <= '0;
            col_q       <= '0;
            wr_ptr_q    <= '0;
        end else if (line_start) begin
            cfg_q.scale <= scale_i;
            cfg_q.attr  <= eff_attr(scale_i, attr_i);
            cfg_q.row   <= row_i;
            laddr_q     <= laddr_i;
            aaddr_q     <= aaddr_i;
            rep_q       <= '0;
            bit_q       <= '0;
            col_q       <= '0;
            wr_ptr_q    <= '0;
        end else begin
            if (win) begin
                if (rep_q == 2'(cfg_q.scale)) begin
                    rep_q <= '0;
                    bit_q <= bit_q + 3'd1;
                    if (bit_q == 3'd7) col_q <= col_q + 1'b1;
                end else begin
                    rep_q <= rep_q + 2'd1;
                end
            end
            if (attr_fetch_o) wr_ptr_q <= wr_ptr_q + 1'b1;
        end
    end

    always_comb begin
        ncols      = cols_of(cfg_q.scale);
        slot_start = (rep_q == 2'd0) && (bit_q == 3'd0);
        bmp_char   = (cfg_q.attr == AT_NONE) ? col_q : col_q - 1'b1;

        bmp_fetch_o = win && slot_start && (col_q < ncols)
                    && ((cfg_q.attr == AT_NONE) || (col_q != '0));

        // halfway through the column: attribute for the following column
        attr_fetch_o = win && (cfg_q.attr != AT_NONE) && (cfg_q.row == 3'd0)
                     && (rep_q == 2'd0) && (bit_q == 3'd4)
                     && (col_q < ncols - 1'b1)
                     && ((cfg_q.attr == AT_FULL) || !col_q[0]);

        addr_o = attr_fetch_o ? aaddr_q + AW'(wr_ptr_q)
                              : laddr_q + AW'({bmp_char, 3'b000});

        pos_o.valid = win;
        pos_o.col   = col_q;
        pos_o.bitn  = bit_q;
        cfg_o       = cfg_q;
        wr_ptr_o    = wr_ptr_q;
    end

endmodule

// File: rtl/attrser_attr_buf.sv
module attrser_attr_buf #(
    parameter int DEPTH = 40,
    parameter int DW    = 8,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] ridx,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdata;
    end

    assign rdata = mem[ridx];

endmodule

// File: rtl/attrser_pix.sv
module attrser_pix
    import attrser_pkg::*;
#(
    parameter int         DEPTH   = 40,
    parameter int         IW      = 6,
    parameter logic [3:0] MONO_FG = 4'h7
) (
    input  logic          clk,
    input  logic          rst,
    input  scale_e        scale_i,
    input  attr_e         attr_i,
    input  pos_t          pos_i,
    input  logic          bmp_load_i,
    input  logic [7:0]    data_i,
    input  logic [7:0]    attr_byte_i,
    output logic [IW-1:0] rd_idx_o,
    output logic [3:0]    pix_o
);

    localparam logic [COL_W-1:0] DEPTH_L = COL_W'(DEPTH);

    logic [7:0]       byte_q;
    pos_t             p1_q;
    logic [3:0]       pix_q;

    logic [COL_W-1:0] ch, ridx_full;
    logic             visible, pbit;
    logic [3:0]       colour;

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_q <= '0;
            p1_q   <= '0;
            pix_q  <= '0;
        end else begin
            if (bmp_load_i) byte_q <= data_i;
            p1_q  <= pos_i;
            pix_q <= visible ? colour : 4'h0;
        end
    end

    always_comb begin
        ch        = (attr_i == AT_NONE) ? p1_q.col : p1_q.col - 1'b1;
        ridx_full = (attr_i == AT_HALF) ? (ch >> 1) : ch;
        rd_idx_o  = (ridx_full < DEPTH_L) ? ridx_full[IW-1:0] : '0;

        visible = p1_q.valid && (p1_q.col < cols_of(scale_i))
                && !((attr_i != AT_NONE) && (p1_q.col == '0));

        pbit = byte_q[~p1_q.bitn];

        unique case (attr_i)
            AT_FULL: colour = pbit ? attr_byte_i[7:4] : attr_byte_i[3:0];
            AT_HALF: colour = pbit ? (ch[0] ? attr_byte_i[3:0] : attr_byte_i[7:4])
                                   : 4'h0;
            default: colour = pbit ? MONO_FG : 4'h0;
        endcase
    end

    assign pix_o = pix_q;

endmodule

// File: rtl/attrser_top.sv
module attrser_top
    import attrser_pkg::*;
#(
    parameter int         AW         = 16,
    parameter int         ATTR_DEPTH = 40,
    parameter logic [3:0] MONO_FG    = 4'h7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_start,
    input  logic          win,
    input  logic [2:0]    row_in_char,
    input  logic [1:0]    scale_sel,
    input  logic [1:0]    attr_sel,
    input  logic [AW-1:0] line_addr,
    input  logic [AW-1:0] attr_addr,
    output logic          fetch_req,
    output logic [AW-1:0] fetch_addr,
    input  logic [7:0]    fetch_data,
    output logic [3:0]    pix_out
);

    localparam int IW = $clog2(ATTR_DEPTH);

    line_cfg_t     cfg;
    pos_t          pos;
    logic          bmp_fetch, attr_fetch;
    logic [IW-1:0] wr_ptr, rd_idx;
    logic [7:0]    attr_byte;

    attrser_timing #(.AW(AW), .IW(IW)) u_tim (
        .clk          (clk),
        .rst          (rst),
        .line_start   (line_start),
        .win          (win),
        .row_i        (row_in_char),
        .scale_i      (scale_e'(scale_sel)),
        .attr_i       (attr_e'(attr_sel)),
        .laddr_i      (line_addr),
        .aaddr_i      (attr_addr),
        .cfg_o        (cfg),
        .pos_o        (pos),
        .bmp_fetch_o  (bmp_fetch),
        .attr_fetch_o (attr_fetch),
        .wr_ptr_o     (wr_ptr),
        .addr_o       (fetch_addr)
    );

    attrser_attr_buf #(.DEPTH(ATTR_DEPTH), .DW(8), .IW(IW)) u_buf (
        .clk   (clk),
        .we    (attr_fetch),
        .widx  (wr_ptr),
        .wdata (fetch_data),
        .ridx  (rd_idx),
        .rdata (attr_byte)
    );

    attrser_pix #(.DEPTH(ATTR_DEPTH), .IW(IW), .MONO_FG(MONO_FG)) u_pix (
        .clk         (clk),
        .rst         (rst),
        .scale_i     (cfg.scale),
        .attr_i      (cfg.attr),
        .pos_i       (pos),
        .bmp_load_i  (bmp_fetch),
        .data_i      (fetch_data),
        .attr_byte_i (attr_byte),
        .rd_idx_o    (rd_idx),
        .pix_o       (pix_out)
    );

    assign fetch_req = bmp_fetch | attr_fetch;

endmodule

// File: rtl/attrser_chk.sv
module attrser_chk (
    input logic       clk,
    input logic       rst,
    input logic       win,
    input logic       fetch_req,
    input logic       attr_fetch,
    input logic [3:0] pix_out,
    input logic [2:0] row_q,
    input logic [1:0] scale_q
);

    logic win_d1, win_d2;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_d1 <= 1'b0;
            win_d2 <= 1'b0;
        end else begin
            win_d1 <= win;
            win_d2 <= win_d1;
        end
    end

    // R9
    fetch_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_req |-> win);

    // R9
    blank_outside_chk: assert property (@(posedge clk) disable iff (rst)
        !win_d2 |-> (pix_out == 4'h0));

    // R7
    attr_row_zero_chk: assert property (@(posedge clk) disable iff (rst)
        attr_fetch |-> (row_q == 3'd0));

    // R8
    attr_no_x1_chk: assert property (@(posedge clk) disable iff (rst)
        attr_fetch |-> (scale_q != 2'd0));

    // R4
    fetch_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_req |=> !fetch_req);

endmodule

bind attrser_top attrser_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .win        (win),
    .fetch_req  (fetch_req),
    .attr_fetch (attr_fetch),
    .pix_out    (pix_out),
    .row_q      (cfg.row),
    .scale_q    (cfg.scale)
);

// File: tb/attrser_top_tb.sv
module attrser_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line_start = 1'b0;
    logic        win = 1'b0;
    logic [2:0]  row_in_char = '0;
    logic [1:0]  scale_sel = '0;
    logic [1:0]  attr_sel = '0;
    logic [15:0] line_addr = '0;
    logic [15:0] attr_addr = '0;
    logic        fetch_req;
    logic [15:0] fetch_addr;
    logic [7:0]  fetch_data;
    logic [3:0]  pix_out;

    logic [7:0]  mem_key = '0;
    logic [15:0] aa0 = '0;
    logic [7:0]  key0 = '0;
    int          n_chk = 0;
    int          n_bad = 0;
    int          n_fetch = 0;
    int          cyc = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    attrser_top dut_i (
        .clk(clk), .rst(rst), .line_start(line_start), .win(win),
        .row_in_char(row_in_char), .scale_sel(scale_sel), .attr_sel(attr_sel),
        .line_addr(line_addr), .attr_addr(attr_addr),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_data(fetch_data), .pix_out(pix_out)
    );

    function automatic logic [7:0] mem_fn(logic [15:0] a, logic [7:0] k);
        return a[7:0] ^ {a[10:8], a[15:11]} ^ (a[7:0] << 3) ^ k;
    endfunction

    assign fetch_data = mem_fn(fetch_addr, mem_key);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst && fetch_req) n_fetch <= n_fetch + 1;
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        wait (cyc > 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, got=%0d exp<190000", cyc);
        finish_run();
    end

    task automatic check(input logic [3:0] got, input logic [3:0] exp,
                         input string tag, input int pos);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s pos=%0d got=%0h exp=%0h", tag, pos, got, exp);
        end
    endtask

    function automatic int eff_mode(int s, int a);
        return (s == 0 || a == 3) ? 0 : a;
    endfunction

    // expected colour at window position c
    function automatic logic [3:0] exp_pix(int c, int s, int m, logic [15:0] la,
                                           logic [7:0] key);
        int sc, p, col, bn, nc, ch, aidx;
        logic [7:0] by, at;
        logic b;
        sc = s + 1; p = 8 * sc; col = c / p; bn = (c % p) / sc; nc = 640 / p;
        if (col >= nc) return 4'h0;
        if (m != 0 && col == 0) return 4'h0;
        ch = (m == 0) ? col : col - 1;
        by = mem_fn(la + 16'(8 * ch), key);
        b = by[7 - bn];
        if (m == 0) return b ? 4'h7 : 4'h0;
        aidx = (m == 1) ? ch : ch / 2;
        at = mem_fn(aa0 + 16'(aidx), key0);
        if (m == 1) return b ? at[7:4] : at[3:0];
        if (!b) return 4'h0;
        return (ch % 2 == 1) ? at[3:0] : at[7:4];
    endfunction

    function automatic string tag_of(int c, int s, int a, int m, int row, bit pert);
        int p, col;
        p = 8 * (s + 1); col = c / p;
        if (pert && c > 100) return "R1 R10";
        if (col >= 640 / p) return "R1 R2";
        if (m != 0 && col == 0) return "R1 R4";
        if (m == 0) return (s == 0 && a != 0) ? "R1 R8" : "R1 R3";
        if (row != 0) return "R1 R7";
        return (m == 1) ? "R1 R5" : "R1 R6";
    endfunction

    task automatic run_line(input int s, input int a, input int row,
                            input logic [15:0] la, input logic [15:0] aa,
                            input logic [7:0] key, input bit pert);
        int m, nc, exp_f;
        m = eff_mode(s, a);
        @(negedge clk);
        scale_sel = 2'(s); attr_sel = 2'(a); row_in_char = 3'(row);
        line_addr = la; attr_addr = aa; mem_key = key; line_start = 1'b1;
        if (row == 0) begin aa0 = aa; key0 = key; end
        @(negedge clk);
        line_start = 1'b0;
        n_fetch = 0;
        win = 1'b1;
        for (int c = 0; c < 642; c++) begin
            if (c == 640) win = 1'b0;
            if (c >= 2)
                check(pix_out, exp_pix(c - 2, s, m, la, key),
                      tag_of(c - 2, s, a, m, row, pert), c - 2);
            if (pert && c == 100) begin
                scale_sel = 2'($urandom); attr_sel = 2'($urandom);
                row_in_char = 3'($urandom);
                line_addr = 16'($urandom); attr_addr = 16'($urandom);
            end
            @(negedge clk);
        end
        // R9: position 640 is outside the window
        check(pix_out, 4'h0, "R9", 640);
        nc = 640 / (8 * (s + 1));
        if (m == 0) exp_f = nc;
        else exp_f = (nc - 1) + ((row == 0) ? ((m == 1) ? nc - 1 : nc / 2) : 0);
        n_chk++;
        if (n_fetch != exp_f) begin
            n_bad++;
            $display("FAIL %s fetch count got=%0d exp=%0d",
                     (m == 0) ? "R3" : ((row == 0) ? "R4" : "R7"), n_fetch, exp_f);
        end
    endtask

    task automatic run_char_row(input int s, input int a, input logic [15:0] lb,
                                input bit pert);
        for (int r = 0; r < 8; r++)
            run_line(s, a, r, lb + 16'(r), 16'($urandom), 8'($urandom),
                     pert && (r == 3 || r == 0));
    endtask

    initial begin
        void'($urandom(32'h5EED_0A77));
        rst = 1'b1;
        repeat (4) @(negedge clk);
        // R9 reset state
        check(pix_out, 4'h0, "R9", -1);
        n_chk++;
        if (fetch_req !== 1'b0) begin
            n_bad++;
            $display("FAIL R9 fetch_req in reset got=%0b exp=0", fetch_req);
        end
        rst = 1'b0;
        @(negedge clk);
        check(pix_out, 4'h0, "R9", -1);

        // directed corners
        run_line(0, 0, 0, 16'h3000, 16'h0000, 8'h00, 0);   // R3 x1 mono
        run_line(0, 1, 0, 16'h3100, 16'h5000, 8'h5A, 0);   // R8 attr ignored at x1
        run_line(1, 3, 0, 16'h3200, 16'h5100, 8'hA5, 0);   // R8 code 3 is off
        run_char_row(1, 1, 16'h4000, 0);                   // R5 R7 x2 full
        run_char_row(1, 2, 16'h4400, 0);                   // R6 R7 x2 half
        run_char_row(2, 1, 16'h4800, 0);                   // R2 x3 tail blank
        run_char_row(3, 2, 16'h4C00, 0);                   // R6 x4 half
        run_char_row(2, 2, 16'h5000, 0);                   // R6 odd column count

        // random mix, some with mid-line input changes (R10)
        for (int i = 0; i < 6; i++)
            run_char_row(1 + int'($urandom % 3), 1 + int'($urandom % 2),
                         16'($urandom), (i % 2) == 1);
        for (int i = 0; i < 3; i++)
            run_line(int'($urandom % 4), 0, int'($urandom % 8), 16'($urandom),
                     16'($urandom), 8'($urandom), 1);

        finish_run();
    end

endmodule